// File: doc/BRIEF.md
# Per-CPU Interrupt Signalling Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers one candidate interrupt: an ID, an 8-bit priority and, for software-generated IDs, the number of the CPU that raised it. The block decides whether that candidate may reach the processor and drives a single `irq` line. The decision depends on three things: an enable bit, a priority threshold, and whether the ID is already being serviced.

Software talks to the block over a small 32-bit register bus. The register layout uses byte offsets:

| Offset | Register |
|---|---|
| 0x00 | Control |
| 0x04 | Priority threshold |
| 0x0C | Claim (read only) |
| 0x10 | Completion (write only) |

Reading the claim register hands the current candidate to software and marks its ID in-service. While the ID is in-service it is kept off the `irq` line. Writing an ID to the completion register ends service of that ID. If nothing is eligible, a claim returns the reserved value 1023, which tells the handler loop to stop.

Read data is registered. A read issued in one cycle returns its data on `bus_rdata` from the next clock edge onward. Writes take effect at the clock edge that accepts them.

Top module: `cpu_irq_if`

## Requirements
- R1: After reset, `irq` is low and both the control register and the priority threshold read back as 0.
- R2: Bit 0 of the control register (offset 0x00) gates `irq`. With the bit clear, `irq` stays low whatever the candidate is.
- R3: A candidate raises `irq` only when its priority is numerically below the threshold (offset 0x04). Equal values are blocked. The threshold keeps only its low 8 bits.
- R4: A claim read (offset 0x0C) of an eligible candidate returns its ID in bits [9:0] and marks that ID in-service. From the next cycle that ID no longer raises `irq`.
- R5: When no candidate is eligible (none valid, blocked by the threshold, or already in-service), a claim returns 1023 in bits [9:0] with all other bits zero, and no state changes.
- R6: For IDs 0 to 15, the claim value carries the requesting CPU number in bits [12:10]. For IDs 16 and above, those bits are zero.
- R7: A completion write (offset 0x10) of an in-service ID clears its in-service state, so the same candidate can raise `irq` again.
- R8: A completion write naming an ID that is not in-service has no effect: IDs that are already in-service stay in-service.
- R9: A completion write takes the ID from bits [9:0] only. Writing back the whole claim word, upper bits included, completes the ID.
- R10: Only candidate IDs 0 to 510 can be signalled or claimed. A candidate with a larger ID keeps `irq` low and claims as 1023.
- R11: Claiming does not depend on the enable bit. With signalling disabled, an eligible candidate can still be claimed by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority; a lower value ranks higher |
| cand_src | input | 3 | Requesting CPU, used for IDs 0 to 15 |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Corrupted in-service state is the main risk, and it shows up in two ways at the ports. If the block fails to mark an ID, `irq` stays high in the cycle after the claim and a second claim returns that ID again instead of 1023. If it wrongly clears an ID, `irq` rises again in the cycle after an unrelated completion write. Either error therefore appears one cycle after the bus access that caused it. A stale threshold or enable bit shows up as soon as the candidate changes around the threshold, and the scenarios place candidates on both sides of it, including equality. The claim word is compared field by field, so a misplaced CPU-number field or ID field is caught on the first claim that returns it.

// File: rtl/cpu_irq_if_pkg.sv
package cpu_irq_if_pkg;
   localparam int ID_W        = 10;
   localparam int SGI_COUNT   = 16;
   localparam int SPURIOUS_ID = 1023;
   localparam int OFS_CTRL    = 'h00;
   localparam int OFS_THRESH  = 'h04;
   localparam int OFS_CLAIM   = 'h0C;
   localparam int OFS_DONE    = 'h10;
endpackage

// File: rtl/cpu_irq_if_regs.sv
module cpu_irq_if_regs
   import cpu_irq_if_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] claim_word,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              ctrl_en,
   output logic [PRIO_W-1:0] prio_mask,
   output logic              claim_rd,
   output logic              done_wr,
   output logic [ID_W-1:0]   done_id
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(OFS_THRESH);
   localparam logic [ADDR_W-1:0] A_CLAIM  = ADDR_W'(OFS_CLAIM);
   localparam logic [ADDR_W-1:0] A_DONE   = ADDR_W'(OFS_DONE);

   if (ADDR_W < 5) begin : g_bad_addr
      $error("cpu_irq_if_regs: ADDR_W too small for register map");
   end
   if (DATA_W < PRIO_W || DATA_W < ID_W) begin : g_bad_data
      $error("cpu_irq_if_regs: DATA_W too narrow");
   end

   assign claim_rd = bus_req && !bus_we && (bus_addr == A_CLAIM);
   assign done_wr  = bus_req &&  bus_we && (bus_addr == A_DONE);
   assign done_id  = bus_wdata[ID_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_en   <= 1'b0;
         prio_mask <= '0;
         bus_rdata <= '0;
      end else if (bus_req) begin
         if (bus_we) begin
            if (bus_addr == A_CTRL) begin
               ctrl_en <= bus_wdata[0];
            end else if (bus_addr == A_THRESH) begin
               prio_mask <= bus_wdata[PRIO_W-1:0];
            end
         end else begin
            if (bus_addr == A_CTRL) begin
               bus_rdata <= DATA_W'(ctrl_en);
            end else if (bus_addr == A_THRESH) begin
               bus_rdata <= DATA_W'(prio_mask);
            end else if (bus_addr == A_CLAIM) begin
               bus_rdata <= claim_word;
            end else begin
               bus_rdata <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/cpu_irq_if_active.sv
module cpu_irq_if_active
   import cpu_irq_if_pkg::*;
#(
   parameter int MAX_ID = 510
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            set_en,
   input  logic [ID_W-1:0] set_id,
   input  logic            clr_en,
   input  logic [ID_W-1:0] clr_id,
   input  logic [ID_W-1:0] probe_id,
   output logic            probe_active,
   output logic [MAX_ID:0] active_vec
);
   localparam int              IDX_W = $clog2(MAX_ID + 1);
   localparam logic [ID_W-1:0] MAX_V = ID_W'(MAX_ID);

   if (MAX_ID >= SPURIOUS_ID) begin : g_bad_max
      $error("cpu_irq_if_active: MAX_ID collides with spurious ID");
   end

   for (genvar i = 0; i <= MAX_ID; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst) begin
            active_vec[i] <= 1'b0;
         end else if (set_en && set_id == ID_W'(i)) begin
            active_vec[i] <= 1'b1;
         end else if (clr_en && clr_id == ID_W'(i)) begin
            active_vec[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      probe_active = 1'b0;
      if (probe_id <= MAX_V) begin
         probe_active = active_vec[probe_id[IDX_W-1:0]];
      end
   end
endmodule

// File: rtl/cpu_irq_if_gate.sv
module cpu_irq_if_gate
   import cpu_irq_if_pkg::*;
#(
   parameter int MAX_ID = 510,
   parameter int PRIO_W = 8,
   parameter int SRC_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [SRC_W-1:0]  cand_src,
   input  logic              cand_active,
   input  logic              ctrl_en,
   input  logic [PRIO_W-1:0] prio_mask,
   output logic              eligible,
   output logic              irq,
   output logic [DATA_W-1:0] claim_word
);
   localparam logic [ID_W-1:0] MAX_V  = ID_W'(MAX_ID);
   localparam logic [ID_W-1:0] SPUR_V = ID_W'(SPURIOUS_ID);
   localparam logic [ID_W-1:0] SGI_V  = ID_W'(SGI_COUNT);

   if (DATA_W < ID_W + SRC_W) begin : g_bad_word
      $error("cpu_irq_if_gate: claim word too narrow");
   end

   logic [SRC_W-1:0] src_field;

   assign eligible = cand_valid && (cand_id <= MAX_V) && !cand_active
                     && (cand_prio < prio_mask);
   assign irq      = eligible && ctrl_en;

   if (SRC_W > 0) begin : g_src
      assign src_field = (eligible && cand_id < SGI_V) ? cand_src : '0;
   end else begin : g_nosrc
      assign src_field = '0;
   end

   always_comb begin
      claim_word                  = '0;
      claim_word[ID_W-1:0]        = eligible ? cand_id : SPUR_V;
      claim_word[ID_W +: SRC_W]   = src_field;
   end
endmodule

// File: rtl/cpu_irq_if.sv
module cpu_irq_if
   import cpu_irq_if_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int PRIO_W = 8,
   parameter int SRC_W  = 3,
   parameter int MAX_ID = 510
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [SRC_W-1:0]  cand_src,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   logic              ctrl_en;
   logic [PRIO_W-1:0] prio_mask;
   logic              claim_rd;
   logic              done_wr;
   logic [ID_W-1:0]   done_id;
   logic              eligible;
   logic              cand_active;
   logic [DATA_W-1:0] claim_word;
   logic [MAX_ID:0]   active_vec;

   cpu_irq_if_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .claim_word(claim_word),
      .bus_rdata (bus_rdata),
      .ctrl_en   (ctrl_en),
      .prio_mask (prio_mask),
      .claim_rd  (claim_rd),
      .done_wr   (done_wr),
      .done_id   (done_id)
   );

   cpu_irq_if_active #(.MAX_ID(MAX_ID)) u_active (
      .clk         (clk),
      .rst         (rst),
      .set_en      (claim_rd && eligible),
      .set_id      (cand_id),
      .clr_en      (done_wr),
      .clr_id      (done_id),
      .probe_id    (cand_id),
      .probe_active(cand_active),
      .active_vec  (active_vec)
   );

   cpu_irq_if_gate #(.MAX_ID(MAX_ID), .PRIO_W(PRIO_W), .SRC_W(SRC_W),
                     .DATA_W(DATA_W)) u_gate (
      .cand_valid (cand_valid),
      .cand_id    (cand_id),
      .cand_prio  (cand_prio),
      .cand_src   (cand_src),
      .cand_active(cand_active),
      .ctrl_en    (ctrl_en),
      .prio_mask  (prio_mask),
      .eligible   (eligible),
      .irq        (irq),
      .claim_word (claim_word)
   );
endmodule

// File: rtl/cpu_irq_if_chk.sv
module cpu_irq_if_chk
   import cpu_irq_if_pkg::*;
#(
   parameter int PRIO_W = 8,
   parameter int MAX_ID = 510
) (
   input logic              clk,
   input logic              rst,
   input logic              irq,
   input logic              ctrl_en,
   input logic [PRIO_W-1:0] prio_mask,
   input logic [PRIO_W-1:0] cand_prio,
   input logic [ID_W-1:0]   cand_id,
   input logic              claim_rd,
   input logic              eligible,
   input logic              done_wr,
   input logic [ID_W-1:0]   done_id,
   input logic [MAX_ID:0]   active_vec
);
   localparam int              IDX_W = $clog2(MAX_ID + 1);
   localparam logic [ID_W-1:0] MAX_V = ID_W'(MAX_ID);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !irq);

   // R2
   enable_gates_chk: assert property (@(posedge clk) disable iff (rst)
      !ctrl_en |-> !irq);

   // R3
   below_mask_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> (cand_prio < prio_mask));

   // R4
   claim_marks_chk: assert property (@(posedge clk) disable iff (rst)
      (claim_rd && eligible) |=> active_vec[$past(cand_id[IDX_W-1:0])]);

   // R4
   no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> !active_vec[cand_id[IDX_W-1:0]]);

   // R7
   done_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (done_wr && done_id <= MAX_V) |=> !active_vec[$past(done_id[IDX_W-1:0])]);

   // R8
   stray_done_chk: assert property (@(posedge clk) disable iff (rst)
      (done_wr && done_id <= MAX_V && !active_vec[done_id[IDX_W-1:0]])
      |=> $stable(active_vec));

   // R10
   id_range_chk: assert property (@(posedge clk) disable iff (rst)
      irq |-> (cand_id <= MAX_V));
endmodule

bind cpu_irq_if cpu_irq_if_chk #(.PRIO_W(PRIO_W), .MAX_ID(MAX_ID)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .irq       (irq),
   .ctrl_en   (ctrl_en),
   .prio_mask (prio_mask),
   .cand_prio (cand_prio),
   .cand_id   (cand_id),
   .claim_rd  (claim_rd),
   .eligible  (eligible),
   .done_wr   (done_wr),
   .done_id   (done_id),
   .active_vec(active_vec)
);

// File: tb/cpu_irq_if_bench.sv
module cpu_irq_if_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cand_valid = 1'b0;
   logic [9:0]  cand_id = '0;
   logic [7:0]  cand_prio = '0;
   logic [2:0]  cand_src = '0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] rd;

   localparam logic [4:0] CTRL = 5'h00, THR = 5'h04, CLAIM = 5'h0C, DONE = 5'h10;
   localparam logic [31:0] SPUR = 32'd1023;

   cpu_irq_if u_cpu_irq_if (
      .clk(clk), .rst(rst), .cand_valid(cand_valid), .cand_id(cand_id),
      .cand_prio(cand_prio), .cand_src(cand_src), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
   endtask

   task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p,
                        input logic [2:0] s);
      @(negedge clk);
      cand_valid = v; cand_id = id; cand_prio = p; cand_src = s;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 irq after reset", 32'(irq), 32'd0);
      bus_read(CTRL, rd);
      check("R1 control reset", rd, 32'd0);
      bus_read(THR, rd);
      check("R1 threshold reset", rd, 32'd0);
   endtask

   task automatic t_enable;
      bus_write(THR, 32'hF0);
      offer(1'b1, 10'd40, 8'h10, 3'd5);
      check("R2 disabled keeps irq low", 32'(irq), 32'd0);
      bus_write(CTRL, 32'd1);
      check("R2 enabled raises irq", 32'(irq), 32'd1);
      bus_read(CTRL, rd);
      check("R2 control readback", rd, 32'd1);
      bus_write(CTRL, 32'd0);
      check("R2 disable drops irq", 32'(irq), 32'd0);
      bus_write(CTRL, 32'd1);
   endtask

   task automatic t_mask;
      offer(1'b1, 10'd40, 8'hF0, 3'd0);
      check("R3 equal priority blocked", 32'(irq), 32'd0);
      offer(1'b1, 10'd40, 8'hEF, 3'd0);
      check("R3 just below passes", 32'(irq), 32'd1);
      bus_write(THR, 32'h1A5);
      bus_read(THR, rd);
      check("R3 threshold 8-bit", rd, 32'hA5);
      bus_write(THR, 32'hF0);
   endtask

   task automatic t_claim;
      offer(1'b1, 10'd40, 8'h10, 3'd5);
      bus_read(CLAIM, rd);
      check("R4 claim returns id", rd, 32'd40);
      check("R6 no source for id>=16", 32'(rd[12:10]), 32'd0);
      check("R4 irq drops after claim", 32'(irq), 32'd0);
      bus_read(CLAIM, rd);
      check("R5 in-service claims spurious", rd, SPUR);
   endtask

   task automatic t_done;
      bus_write(DONE, 32'd41);
      check("R8 stray completion ignored", 32'(irq), 32'd0);
      bus_read(CLAIM, rd);
      check("R8 id 40 still in service", rd, SPUR);
      bus_write(DONE, 32'd40);
      check("R7 completion re-presents", 32'(irq), 32'd1);
      bus_read(CLAIM, rd);
      check("R7 claim after completion", rd, 32'd40);
      bus_write(DONE, 32'd40);
   endtask

   task automatic t_sgi;
      offer(1'b1, 10'd3, 8'h20, 3'd5);
      bus_read(CLAIM, rd);
      check("R6 software id with source", rd, 32'h1403);
      check("R6 irq drops after claim", 32'(irq), 32'd0);
      bus_write(DONE, 32'h8000_0000 | rd);
      check("R9 full word completes", 32'(irq), 32'd1);
      bus_read(CLAIM, rd);
      check("R9 reclaim after completion", rd, 32'h1403);
      bus_write(DONE, rd);
   endtask

   task automatic t_none;
      offer(1'b0, 10'd40, 8'h10, 3'd0);
      check("R5 no candidate irq low", 32'(irq), 32'd0);
      bus_read(CLAIM, rd);
      check("R5 empty claim spurious", rd, SPUR);
      offer(1'b1, 10'd40, 8'hFF, 3'd0);
      bus_read(CLAIM, rd);
      check("R5 masked claim spurious", rd, SPUR);
      offer(1'b1, 10'd40, 8'h10, 3'd0);
      check("R5 spurious claim changed nothing", 32'(irq), 32'd1);
   endtask

   task automatic t_range;
      offer(1'b1, 10'd511, 8'h00, 3'd0);
      check("R10 id 511 not signalled", 32'(irq), 32'd0);
      bus_read(CLAIM, rd);
      check("R10 id 511 claims spurious", rd, SPUR);
      offer(1'b1, 10'd510, 8'h00, 3'd0);
      check("R10 id 510 signalled", 32'(irq), 32'd1);
      bus_read(CLAIM, rd);
      check("R10 id 510 claimed", rd, 32'd510);
      bus_write(DONE, 32'd510);
      check("R10 id 510 completed", 32'(irq), 32'd1);
   endtask

   task automatic t_disabled_claim;
      bus_write(CTRL, 32'd0);
      offer(1'b1, 10'd100, 8'h30, 3'd0);
      check("R11 disabled irq low", 32'(irq), 32'd0);
      bus_read(CLAIM, rd);
      check("R11 claim while disabled", rd, 32'd100);
      bus_write(CTRL, 32'd1);
      check("R11 claimed id stays off", 32'(irq), 32'd0);
      bus_write(DONE, 32'd100);
      check("R11 completion restores irq", 32'(irq), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_enable();
      t_mask();
      t_claim();
      t_done();
      t_sgi();
      t_none();
      t_range();
      t_disabled_claim();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule